// File: doc/BRIEF.md
# Single-Cycle Register Machine Core

This block is a small in-order processor that finishes one instruction in every clock cycle. It has no pipeline. Arithmetic works only between registers. Only two instructions touch data memory: one moves a word from memory into a register, the other moves a register into memory. The core holds a program counter, a file of sixteen 16-bit registers, a four-function ALU, the decode logic and the next-address logic.

The core reads instruction memory through a combinational port: the address is the program counter and the word comes back in the same cycle. Data memory uses a combinational read port and a synchronous write strobe. Both memories sit outside the core.

Control flow has one instruction only, a conditional jump. It tests one register for zero and takes its target from a second register. A program builds an unconditional jump by testing a register that holds zero. A separate instruction copies the program counter into a register, so a program can compute return targets.

The reset input is active-low and asserts asynchronously. Its release is synchronised inside the core, so execution starts two clock edges after reset is released.

Top module: `sc6_core`

## Requirements
- R1: While reset is asserted, `imem_addr` is 0 and `dmem_we` is low. Execution begins at address 0 with every register holding 0.
- R2: Opcode 000 (bits 15:13) is load-constant. It writes the 8-bit immediate in bits 8:1, zero-extended, into the register named by bits 12:9.
- R3: Opcode 001 is load-PC. It writes the address of the instruction itself, zero-extended, into the register named by bits 12:9.
- R4: Opcodes 010 and 011 are the ALU instruction. The function code is {opcode bit 0, word bit 0}: 00 add, 01 subtract, 10 AND, 11 OR. Operand A is the register named by bits 8:5 and operand B is the register named by bits 4:1. The 16-bit result wraps and is written to the register named by bits 12:9.
- R5: Opcode 100 is jump-if-zero. If the register named by bits 8:5 is zero, the next PC is the low 8 bits of the register named by bits 4:1. Otherwise the next PC is PC+1.
- R6: Opcode 101 is load. It writes `dmem_rdata` into the register named by bits 12:9. The address is the low 8 bits of the register named by bits 8:5.
- R7: Opcode 110 is store. It raises `dmem_we` for that one cycle. `dmem_addr` is the low 8 bits of the register named by bits 8:5, and `dmem_wdata` is the register named by bits 4:1. `dmem_we` is never high for any other opcode.
- R8: Every instruction other than jump-if-zero advances the PC by exactly one. The PC wraps from 255 to 0.
- R9: Opcode 111 is illegal. It changes no register and does not write memory, and the PC advances by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the core |
| imem_addr | output | 8 | Program counter, used as the instruction fetch address |
| imem_rdata | input | 16 | Instruction word at `imem_addr` |
| dmem_addr | output | 8 | Data memory address, taken from the first source register |
| dmem_we | output | 1 | Data memory write strobe, high only during a store |
| dmem_wdata | output | 16 | Store data, taken from the second source register |
| dmem_rdata | input | 16 | Data memory word at `dmem_addr` |

## Verification
The core is tested with three programs, each run against an instruction-level reference model.

- **Straight-line program:** exercises every ALU function, including a subtract that borrows and an AND that yields zero. It also stores a register that has never been written, which shows the reset value. An illegal opcode aimed at a live register shows whether that instruction leaks into the register file.
- **Counted loop:** separates a taken jump-if-zero from an untaken one. It also checks that a load returns data written by earlier stores.
- **Jump to the top of the address space:** runs code at the last addresses, so the PC must wrap to zero and load-PC must report high addresses correctly.

Each store is compared against the reference, and each mismatch is reported under the requirement of the instruction that last wrote the stored register.

// File: rtl/sc6_pkg.sv
package sc6_pkg;

  localparam int OPC_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OPC_LDC  = 3'd0,
    OPC_LDPC = 3'd1,
    OPC_ALU0 = 3'd2,
    OPC_ALU1 = 3'd3,
    OPC_JZ   = 3'd4,
    OPC_LD   = 3'd5,
    OPC_ST   = 3'd6,
    OPC_BAD  = 3'd7
  } opc_e;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_AND = 2'd2,
    FN_OR  = 2'd3
  } alu_fn_e;

  typedef enum logic [1:0] {
    WB_IMM = 2'd0,
    WB_PC  = 2'd1,
    WB_ALU = 2'd2,
    WB_MEM = 2'd3
  } wb_sel_e;

  typedef struct packed {
    logic    rf_we;
    wb_sel_e wb_sel;
    logic    mem_we;
    logic    is_jz;
    alu_fn_e fn;
  } ctl_t;

endpackage

// File: rtl/sc6_decode.sv
module sc6_decode
  import sc6_pkg::*;
#(
  parameter int INSN_W = 16,
  parameter int REG_AW = 4,
  parameter int IMM_W  = 8
) (
  input  logic [INSN_W-1:0] insn,
  output ctl_t              ctl,
  output logic [REG_AW-1:0] rd,
  output logic [REG_AW-1:0] ra,
  output logic [REG_AW-1:0] rb,
  output logic [IMM_W-1:0]  imm
);

  localparam int OP_LSB = INSN_W - OPC_W;
  localparam int RD_LSB = OP_LSB - REG_AW;
  localparam int RA_LSB = RD_LSB - REG_AW;
  localparam int RB_LSB = RA_LSB - REG_AW;
  localparam int FN_BIT = 0;

  opc_e opc;

  assign opc = opc_e'(insn[OP_LSB +: OPC_W]);
  assign rd  = insn[RD_LSB +: REG_AW];
  assign ra  = insn[RA_LSB +: REG_AW];
  assign rb  = insn[RB_LSB +: REG_AW];
  // immediate overlays both source register fields
  assign imm = insn[RB_LSB +: IMM_W];

  always_comb begin
    ctl        = '0;
    ctl.wb_sel = WB_ALU;
    ctl.fn     = alu_fn_e'({insn[OP_LSB], insn[FN_BIT]});
    unique case (opc)
      OPC_LDC:  begin ctl.rf_we = 1'b1; ctl.wb_sel = WB_IMM; end
      OPC_LDPC: begin ctl.rf_we = 1'b1; ctl.wb_sel = WB_PC;  end
      OPC_ALU0,
      OPC_ALU1: begin ctl.rf_we = 1'b1; ctl.wb_sel = WB_ALU; end
      OPC_JZ:   ctl.is_jz = 1'b1;
      OPC_LD:   begin ctl.rf_we = 1'b1; ctl.wb_sel = WB_MEM; end
      OPC_ST:   ctl.mem_we = 1'b1;
      default:  ctl.rf_we = 1'b0;
    endcase
  end

endmodule

// File: rtl/sc6_regfile.sv
module sc6_regfile #(
  parameter int DATA_W = 16,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [REG_AW-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [REG_AW-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);

  localparam int NREG = 1 << REG_AW;

  logic [DATA_W-1:0] regs_q [NREG];

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    logic              en;
    logic [DATA_W-1:0] d;

    assign en = we && (waddr == REG_AW'(gi));

    always_comb begin
      d = regs_q[gi];
      if (en) d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs_q[gi] <= '0;
      else if (en) regs_q[gi] <= d;
    end
  end

  assign rdata_a = regs_q[raddr_a];
  assign rdata_b = regs_q[raddr_b];

endmodule

// File: rtl/sc6_alu.sv
module sc6_alu
  import sc6_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_fn_e           fn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);

  always_comb begin
    unique case (fn)
      FN_ADD:  y = a + b;
      FN_SUB:  y = a - b;
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/sc6_core.sv
module sc6_core
  import sc6_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int INSN_W      = 16,
  parameter int REG_AW      = 4,
  parameter int IMM_W       = 8,
  parameter int IADDR_W     = 8,
  parameter int DADDR_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [IADDR_W-1:0] imem_addr,
  input  logic [INSN_W-1:0]  imem_rdata,
  output logic [DADDR_W-1:0] dmem_addr,
  output logic               dmem_we,
  output logic [DATA_W-1:0]  dmem_wdata,
  input  logic [DATA_W-1:0]  dmem_rdata
);

  // reset release synchroniser
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   run;

  assign sync_d = {sync_q[SYNC_STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign run = sync_q[SYNC_STAGES-1];

  // decode
  ctl_t              ctl;
  logic [REG_AW-1:0] rd, ra, rb;
  logic [IMM_W-1:0]  imm;

  sc6_decode #(.INSN_W(INSN_W), .REG_AW(REG_AW), .IMM_W(IMM_W)) u_dec (
    .insn(imem_rdata), .ctl(ctl), .rd(rd), .ra(ra), .rb(rb), .imm(imm)
  );

  // register file
  logic              rf_we;
  logic [DATA_W-1:0] rf_wdata;
  logic [DATA_W-1:0] ra_val, rb_val;

  sc6_regfile #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_rf (
    .clk(clk), .rst_n(run), .we(rf_we), .waddr(rd), .wdata(rf_wdata),
    .raddr_a(ra), .rdata_a(ra_val), .raddr_b(rb), .rdata_b(rb_val)
  );

  // ALU
  logic [DATA_W-1:0] alu_y;

  sc6_alu #(.DATA_W(DATA_W)) u_alu (
    .fn(ctl.fn), .a(ra_val), .b(rb_val), .y(alu_y)
  );

  // program counter
  logic [IADDR_W-1:0] pc_q, pc_d, pc_inc;
  logic               pc_en;
  logic               take_jump;

  assign pc_inc    = pc_q + IADDR_W'(1);
  assign take_jump = ctl.is_jz && (ra_val == '0);
  assign pc_en     = run;

  always_comb begin
    pc_d = pc_inc;
    if (take_jump) pc_d = rb_val[IADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge run) begin
    if (!run)       pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  // write-back select
  always_comb begin
    unique case (ctl.wb_sel)
      WB_IMM:  rf_wdata = DATA_W'(imm);
      WB_PC:   rf_wdata = DATA_W'(pc_q);
      WB_ALU:  rf_wdata = alu_y;
      default: rf_wdata = dmem_rdata;
    endcase
  end

  assign rf_we      = ctl.rf_we && run;
  assign imem_addr  = pc_q;
  assign dmem_addr  = ra_val[DADDR_W-1:0];
  assign dmem_wdata = rb_val;
  assign dmem_we    = ctl.mem_we && run;

endmodule

// File: rtl/sc6_core_chk.sv
module sc6_core_chk
  import sc6_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int INSN_W  = 16,
  parameter int IADDR_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run,
  input logic [IADDR_W-1:0] imem_addr,
  input logic [INSN_W-1:0]  imem_rdata,
  input logic               dmem_we,
  input logic               rf_we,
  input logic [DATA_W-1:0]  rf_wdata,
  input logic [DATA_W-1:0]  ra_val,
  input logic [IADDR_W-1:0] rb_low
);

  logic [OPC_W-1:0] opc;
  assign opc = imem_rdata[INSN_W-1 -: OPC_W];

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> (imem_addr == '0) && !dmem_we);

  assert_ldpc_writes_pc_R3: assert property (@(posedge clk) disable iff (!run)
    (opc == OPC_LDPC) |-> rf_we && (rf_wdata == DATA_W'(imem_addr)));

  assert_jz_taken_target_R5: assert property (@(posedge clk) disable iff (!run)
    (opc == OPC_JZ) && (ra_val == '0) |=> imem_addr == $past(rb_low));

  assert_store_strobe_only_R7: assert property (@(posedge clk) disable iff (!run)
    dmem_we |-> (opc == OPC_ST));

  assert_store_strobe_always_R7: assert property (@(posedge clk) disable iff (!run)
    (opc == OPC_ST) |-> dmem_we);

  assert_pc_step_R8: assert property (@(posedge clk) disable iff (!run)
    (opc != OPC_JZ) |=> imem_addr == $past(imem_addr) + IADDR_W'(1));

  assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!run)
    (opc == OPC_BAD) |-> !rf_we && !dmem_we);

endmodule

bind sc6_core sc6_core_chk #(
  .DATA_W(DATA_W), .INSN_W(INSN_W), .IADDR_W(IADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .imem_addr(imem_addr),
  .imem_rdata(imem_rdata), .dmem_we(dmem_we), .rf_we(rf_we),
  .rf_wdata(rf_wdata), .ra_val(ra_val), .rb_low(rb_val[IADDR_W-1:0])
);

// File: tb/sim_sc6_core.sv
`timescale 1ns/1ps
module sim_sc6_core;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic [7:0]  imem_addr;
  logic [15:0] imem_rdata;
  logic [7:0]  dmem_addr;
  logic        dmem_we;
  logic [15:0] dmem_wdata;
  logic [15:0] dmem_rdata;
  logic        mem_clr;

  logic [15:0] imem [256];
  logic [15:0] dmem [256];

  assign imem_rdata = imem[imem_addr];
  assign dmem_rdata = dmem[dmem_addr];

  always @(posedge clk) begin
    if (mem_clr) begin
      for (int i = 0; i < 256; i++) dmem[i] <= 16'h0;
    end else if (dmem_we) begin
      dmem[dmem_addr] <= dmem_wdata;
    end
  end

  sc6_core u0 (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_we(dmem_we), .dmem_wdata(dmem_wdata),
    .dmem_rdata(dmem_rdata)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  function automatic string rtag(int t);
    case (t)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 7: return "R7"; 8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(bit ok, int tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rtag(tag), what, act, exp);
    end
  endtask

  // encoders: op[15:13] rd[12:9] ra[8:5] rb[4:1] bit0; imm[8:1]
  function automatic logic [15:0] e_ldc(logic [3:0] rd, logic [7:0] imm);
    return {3'd0, rd, imm, 1'b0};
  endfunction
  function automatic logic [15:0] e_ldpc(logic [3:0] rd);
    return {3'd1, rd, 9'd0};
  endfunction
  function automatic logic [15:0] e_alu(logic [1:0] fn, logic [3:0] rd, logic [3:0] ra, logic [3:0] rb);
    return {2'b01, fn[1], rd, ra, rb, fn[0]};
  endfunction
  function automatic logic [15:0] e_jz(logic [3:0] ra, logic [3:0] rb);
    return {3'd4, 4'd0, ra, rb, 1'b0};
  endfunction
  function automatic logic [15:0] e_ld(logic [3:0] rd, logic [3:0] ra);
    return {3'd5, rd, ra, 5'd0};
  endfunction
  function automatic logic [15:0] e_st(logic [3:0] ra, logic [3:0] rb);
    return {3'd6, 4'd0, ra, rb, 1'b0};
  endfunction
  function automatic logic [15:0] e_bad(logic [3:0] rd, logic [3:0] ra, logic [3:0] rb);
    return {3'd7, rd, ra, rb, 1'b1};
  endfunction

  typedef struct {
    logic [7:0]  pc;
    logic        we;
    logic [7:0]  addr;
    logic [15:0] data;
    int          pc_tag;
    int          data_tag;
  } exp_t;

  exp_t sb [$];

  // driver: reference interpreter pushes one expected item per cycle
  task automatic push_expected(int steps);
    logic [15:0] rr [16];
    int          wtag [16];
    logic [15:0] mm [256];
    logic [7:0]  pc = 8'd0;
    int          prev = 1;
    for (int i = 0; i < 16; i++) begin rr[i] = 16'h0; wtag[i] = 1; end
    for (int i = 0; i < 256; i++) mm[i] = 16'h0;
    for (int k = 0; k < steps; k++) begin
      exp_t        it;
      logic [15:0] w  = imem[pc];
      logic [2:0]  op = w[15:13];
      logic [3:0]  rd = w[12:9];
      logic [3:0]  ra = w[8:5];
      logic [3:0]  rb = w[4:1];
      logic [15:0] a  = rr[ra];
      logic [15:0] b  = rr[rb];
      logic [7:0]  npc = pc + 8'd1;
      it.pc = pc; it.pc_tag = prev; it.we = 1'b0;
      it.addr = 8'h0; it.data = 16'h0; it.data_tag = 7;
      prev = 8;
      case (op)
        3'd0: begin rr[rd] = {8'h0, w[8:1]}; wtag[rd] = 2; end
        3'd1: begin rr[rd] = {8'h0, pc}; wtag[rd] = 3; end
        3'd2, 3'd3: begin
          case ({op[0], w[0]})
            2'd0: rr[rd] = a + b;
            2'd1: rr[rd] = a - b;
            2'd2: rr[rd] = a & b;
            default: rr[rd] = a | b;
          endcase
          wtag[rd] = 4;
        end
        3'd4: begin
          if (a == 16'h0) npc = b[7:0];
          prev = 5;
        end
        3'd5: begin rr[rd] = mm[a[7:0]]; wtag[rd] = 6; end
        3'd6: begin
          it.we = 1'b1; it.addr = a[7:0]; it.data = b; it.data_tag = wtag[rb];
          mm[a[7:0]] = b;
        end
        default: prev = 9;
      endcase
      sb.push_back(it);
      pc = npc;
    end
  endtask

  // monitor: pops one item per cycle after reset release
  task automatic run_prog(int steps);
    push_expected(steps);
    @(negedge clk);
    rst_n   = 1'b0;
    mem_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mem_clr = 1'b0;
    // R1: reset state visible at the ports
    check(imem_addr == 8'h0, 1, "pc in reset", int'(imem_addr), 0);
    check(dmem_we == 1'b0, 1, "we in reset", int'(dmem_we), 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    while (sb.size() > 0) begin
      exp_t e;
      @(negedge clk);
      e = sb.pop_front();
      check(imem_addr == e.pc, e.pc_tag, "pc", int'(imem_addr), int'(e.pc));
      check(dmem_we == e.we, 7, "store strobe", int'(dmem_we), int'(e.we));
      if (e.we && dmem_we) begin
        check(dmem_addr == e.addr, 7, "store addr", int'(dmem_addr), int'(e.addr));
        check(dmem_wdata == e.data, e.data_tag, "store data", int'(dmem_wdata), int'(e.data));
      end
    end
  endtask

  task automatic clear_imem();
    for (int i = 0; i < 256; i++) imem[i] = 16'h0;
  endtask

  initial begin
    rst_n   = 1'b0;
    mem_clr = 1'b1;

    // program A: reset registers (R1), constants (R2), ALU (R4), load-PC (R3), illegal (R9)
    clear_imem();
    imem[0]  = e_st(4'd0, 4'd15);
    imem[1]  = e_ldc(4'd1, 8'd200);
    imem[2]  = e_ldc(4'd2, 8'd55);
    imem[3]  = e_ldc(4'd10, 8'd16);
    imem[4]  = e_alu(2'd0, 4'd3, 4'd1, 4'd2);
    imem[5]  = e_st(4'd10, 4'd3);
    imem[6]  = e_alu(2'd1, 4'd4, 4'd2, 4'd1);
    imem[7]  = e_st(4'd10, 4'd4);
    imem[8]  = e_alu(2'd2, 4'd5, 4'd1, 4'd2);
    imem[9]  = e_st(4'd10, 4'd5);
    imem[10] = e_alu(2'd3, 4'd6, 4'd1, 4'd2);
    imem[11] = e_st(4'd10, 4'd6);
    imem[12] = e_ldpc(4'd7);
    imem[13] = e_st(4'd10, 4'd7);
    imem[14] = e_bad(4'd3, 4'd1, 4'd2);
    imem[15] = e_st(4'd10, 4'd3);
    imem[16] = e_ldc(4'd11, 8'd255);
    imem[17] = e_alu(2'd0, 4'd12, 4'd11, 4'd11);
    imem[18] = e_st(4'd11, 4'd12);
    imem[19] = e_ldc(4'd13, 8'd20);
    imem[20] = e_jz(4'd0, 4'd13);
    run_prog(40);

    // program B: counted loop, jump taken and not taken (R5), load (R6)
    clear_imem();
    imem[0]  = e_ldc(4'd1, 8'd5);
    imem[1]  = e_ldc(4'd2, 8'd1);
    imem[2]  = e_ldc(4'd7, 8'd4);
    imem[3]  = e_ldc(4'd8, 8'd8);
    imem[4]  = e_st(4'd1, 4'd1);
    imem[5]  = e_alu(2'd1, 4'd1, 4'd1, 4'd2);
    imem[6]  = e_jz(4'd1, 4'd8);
    imem[7]  = e_jz(4'd0, 4'd7);
    imem[8]  = e_ldc(4'd11, 8'd3);
    imem[9]  = e_ld(4'd9, 4'd11);
    imem[10] = e_ldc(4'd12, 8'h40);
    imem[11] = e_st(4'd12, 4'd9);
    imem[12] = e_ld(4'd9, 4'd12);
    imem[13] = e_st(4'd11, 4'd9);
    imem[14] = e_ldc(4'd13, 8'd15);
    imem[15] = e_jz(4'd0, 4'd13);
    run_prog(60);

    // program C: code at the top of the address space, PC wrap (R8), load-PC high (R3)
    clear_imem();
    imem[0]   = e_ldc(4'd4, 8'd250);
    imem[1]   = e_jz(4'd0, 4'd4);
    imem[250] = e_ldc(4'd5, 8'h5A);
    imem[251] = e_ldc(4'd6, 8'h20);
    imem[252] = e_st(4'd6, 4'd5);
    imem[253] = e_bad(4'd5, 4'd6, 4'd6);
    imem[254] = e_ldpc(4'd7);
    imem[255] = e_st(4'd6, 4'd7);
    run_prog(30);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule